// File: doc/BRIEF.md
# Imaging Array Pre-Exposure Charge Clear Sequencer

This block produces the timing for clearing stored charge from a full-frame imaging array just before an exposure begins. A single start command runs a fixed order of events. The second vertical phase rises while the first stays low, so that every pixel's charge collects under one phase. One drain gate is then pulsed. After the gate drops, the second vertical phase falls. The block then waits out a settling interval and pulses completion.

Two clearing modes are supported. In full mode the array-wide flush gate drains every pixel with one pulse. In row mode a separate dump gate is pulsed instead, so that only the selected line is cleared ahead of a partial readout. Three cycle counts are taken from the inputs when a start is accepted. They set the charge-parking time, the gate pulse width and the settling time that follows the vertical-phase fall.

Top module: `ccd_flush_seq`

## Requirements
- R1: While reset is asserted, and from reset release until a start is accepted, every output is low.
- R2: A start sampled high while idle drives phase B high from the next cycle. Phase B then stays high with both gates low for max(park,1) cycles.
- R3: In full mode (row_mode_i = 0), the flush gate follows the parking time. It is a single pulse lasting max(gate,1) cycles, with phase B high and the dump gate low.
- R4: In row mode (row_mode_i = 1), the dump gate takes the place of the flush gate, with the same pulse timing. The flush gate stays low for the whole sequence.
- R5: After the gate pulse ends, phase B stays high for exactly one more cycle and then falls. No gate is ever high while phase B is low.
- R6: Phase A is low in every cycle.
- R7: Once phase B has fallen, phase B and both gates stay low for 1+max(settle,1) cycles. Done is then high for exactly one cycle, and the block returns to idle.
- R8: A count of zero on any of the three timing inputs behaves as a count of one.
- R9: A start raised while a sequence is running has no effect, and this includes the cycle in which done is high. The mode and the counts are captured only when a start is accepted, so later changes to them do not alter the running sequence.
- R10: The flush gate and the dump gate are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| row_mode_i | input | 1 | 0 selects full-array flush, 1 selects row dump |
| park_cycles_i | input | CNT_W | Phase B high time before the gate pulse |
| gate_cycles_i | input | CNT_W | Gate pulse width |
| settle_cycles_i | input | CNT_W | Settling time after phase B falls |
| vphase_a_o | output | 1 | Vertical phase A drive |
| vphase_b_o | output | 1 | Vertical phase B drive |
| flush_gate_o | output | 1 | Array-wide flush gate |
| dump_gate_o | output | 1 | Row dump gate |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench compares every output in every cycle against a waveform built from the counts. This catches an off-by-one in any interval: such a design would raise the gate too early, hold it one cycle too long, or pulse done before settling has finished. Zero counts are tested in both modes, since a design that did not clamp them would wrap its counter and hang in one state for a very long time. Starts raised in the middle of a sequence and during the done cycle come with altered mode and counts. A design that restarted, or that used the live inputs, would show an unexpected phase B rise or a gate on the wrong pin. Sequences run back to back, so that any state left over from one run would show up as a mismatch in the next.

// File: rtl/ccd_flush_pkg.sv
package ccd_flush_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_GATE_ON,
    ST_GATE_OFF,
    ST_DROP,
    ST_SETTLE,
    ST_DONE
  } flush_state_e;

  typedef struct packed {
    logic vph_a;
    logic vph_b;
    logic flush;
    logic dump;
    logic done;
  } drive_t;
endpackage

// File: rtl/ccd_flush_timer.sv
module ccd_flush_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ccd_flush_fsm.sv
module ccd_flush_fsm
  import ccd_flush_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             row_mode_i,
  input  logic [CNT_W-1:0] park_i,
  input  logic [CNT_W-1:0] gate_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output flush_state_e     state_o,
  output logic             row_mode_o
);
  flush_state_e     state_q, state_d;
  logic [CNT_W-1:0] gate_q, settle_q;
  logic             row_q;
  logic             accept;

  // count N lasts max(N,1) cycles: load N-1, zero maps to zero
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i)   state_d = ST_PARK;
      ST_PARK:     if (expired_i) state_d = ST_GATE_ON;
      ST_GATE_ON:  if (expired_i) state_d = ST_GATE_OFF;
      ST_GATE_OFF:                state_d = ST_DROP;
      ST_DROP:                    state_d = ST_SETTLE;
      ST_SETTLE:   if (expired_i) state_d = ST_DONE;
      ST_DONE:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_PARK:    load_val_o = span(park_i);
      ST_GATE_ON: load_val_o = span(gate_q);
      ST_SETTLE:  load_val_o = span(settle_q);
      default:    load_val_o = '0;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      gate_q   <= '0;
      settle_q <= '0;
      row_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        gate_q   <= gate_i;
        settle_q <= settle_i;
        row_q    <= row_mode_i;
      end
    end
  end

  assign state_o    = state_q;
  assign row_mode_o = row_q;

  // a running sequence never re-enters parking
  assert_busy_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_PARK) |=> (state_q != ST_PARK));
endmodule

// File: rtl/ccd_flush_drive.sv
module ccd_flush_drive
  import ccd_flush_pkg::*;
(
  input  flush_state_e state_i,
  input  logic         row_mode_i,
  output drive_t       drv_o
);
  always_comb begin
    drv_o = '0;
    unique case (state_i)
      ST_PARK, ST_GATE_OFF: drv_o.vph_b = 1'b1;
      ST_GATE_ON: begin
        drv_o.vph_b = 1'b1;
        if (row_mode_i) drv_o.dump  = 1'b1;
        else            drv_o.flush = 1'b1;
      end
      ST_DONE: drv_o.done = 1'b1;
      default: drv_o = '0;
    endcase
  end
endmodule

// File: rtl/ccd_flush_seq.sv
module ccd_flush_seq
  import ccd_flush_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             row_mode_i,
  input  logic [CNT_W-1:0] park_cycles_i,
  input  logic [CNT_W-1:0] gate_cycles_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output logic             vphase_a_o,
  output logic             vphase_b_o,
  output logic             flush_gate_o,
  output logic             dump_gate_o,
  output logic             done_o
);
  flush_state_e     state;
  logic             row_mode;
  logic             load, expired;
  logic [CNT_W-1:0] load_val;
  drive_t           drv;

  ccd_flush_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .row_mode_i (row_mode_i),
    .park_i     (park_cycles_i),
    .gate_i     (gate_cycles_i),
    .settle_i   (settle_cycles_i),
    .expired_i  (expired),
    .load_o     (load),
    .load_val_o (load_val),
    .state_o    (state),
    .row_mode_o (row_mode)
  );

  ccd_flush_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  ccd_flush_drive i_drive (
    .state_i    (state),
    .row_mode_i (row_mode),
    .drv_o      (drv)
  );

  assign vphase_a_o   = drv.vph_a;
  assign vphase_b_o   = drv.vph_b;
  assign flush_gate_o = drv.flush;
  assign dump_gate_o  = drv.dump;
  assign done_o       = drv.done;

  assert_vphase_a_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vphase_a_o);
  assert_gates_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_gate_o && dump_gate_o));
  assert_parked_before_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_gate_o || dump_gate_o) |-> $past(vphase_b_o));
  assert_gate_low_under_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vphase_b_o) |-> (!flush_gate_o && !dump_gate_o && !$past(flush_gate_o || dump_gate_o)));
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_settle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!vphase_b_o && !$past(vphase_b_o)));
endmodule

// File: tb/test_ccd_flush_seq.sv
module test_ccd_flush_seq;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             row_mode = 1'b0;
  logic [CNT_W-1:0] park = '0, gate = '0, settle = '0;
  logic             vph_a, vph_b, flush, dump, done;

  ccd_flush_seq #(.CNT_W(CNT_W)) i_ccd_flush_seq (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .start_i         (start),
    .row_mode_i      (row_mode),
    .park_cycles_i   (park),
    .gate_cycles_i   (gate),
    .settle_cycles_i (settle),
    .vphase_a_o      (vph_a),
    .vphase_b_o      (vph_b),
    .flush_gate_o    (flush),
    .dump_gate_o     (dump),
    .done_o          (done)
  );

  typedef struct {
    logic [4:0] vec;  // {a, b, flush, dump, done}
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   armed = 1'b0;

  task automatic check(logic [4:0] act, logic [4:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic push(logic [4:0] v, string t);
    exp_t e;
    e.vec = v;
    e.tag = t;
    q.push_back(e);
  endtask

  // driver: applies a start and queues the expected per-cycle outputs
  task automatic run_seq(int p, int g, int s, bit row, string force_tag);
    int pe = (p == 0) ? 1 : p;
    int ge = (g == 0) ? 1 : g;
    int se = (s == 0) ? 1 : s;
    @(negedge clk);
    park = CNT_W'(p); gate = CNT_W'(g); settle = CNT_W'(s);
    row_mode = row; start = 1'b1; armed = 1'b1;
    for (int i = 0; i < pe; i++) push(5'b01000, force_tag != "" ? force_tag : "R2");
    for (int i = 0; i < ge; i++)
      push(row ? 5'b01010 : 5'b01100, force_tag != "" ? force_tag : (row ? "R4" : "R3"));
    push(5'b01000, force_tag != "" ? force_tag : "R5");
    push(5'b00000, force_tag != "" ? force_tag : "R5");
    for (int i = 0; i < se; i++) push(5'b00000, force_tag != "" ? force_tag : "R7");
    push(5'b00001, force_tag != "" ? force_tag : "R7");
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares every cycle, away from the clock edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #3;
      if (rst_n) begin
        if (q.size() > 0) e = q.pop_front();
        else begin
          e.vec = 5'b00000;
          e.tag = armed ? "R9" : "R1";
        end
        check({vph_a, vph_b, flush, dump, done}, e.vec, e.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({vph_a, vph_b, flush, dump, done}, 5'b00000, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_seq(3, 4, 2, 1'b0, "");  wait_idle();   // R3 full flush
    run_seq(2, 3, 5, 1'b1, "");  wait_idle();   // R4 row dump
    run_seq(0, 0, 0, 1'b0, "R8"); wait_idle();
    run_seq(0, 0, 0, 1'b1, "R8"); wait_idle();

    // R9: starts mid-sequence with altered inputs, then during done
    run_seq(4, 5, 3, 1'b0, "R9");
    repeat (3) begin
      @(negedge clk);
      start = 1'b1; row_mode = 1'b1;
      park = 7; gate = 7; settle = 7;
    end
    @(negedge clk);
    start = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);

    run_seq(20, 30, 25, 1'b1, ""); wait_idle();
    for (int i = 0; i < 6; i++) begin
      run_seq(i % 3, (i * 2) % 5, i % 4, i[0], "");
      wait_idle();
    end
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule